// File: doc/BRIEF.md
# Single-Cycle Six-Instruction Processor Core

A 32-bit processor core that fetches, decodes, executes, accesses memory and writes back one instruction per clock cycle. It understands six operations: register add and register subtract (modulo 2^32, no trap), OR with a zero-extended 16-bit immediate, word load, word store, and a conditional branch taken when two registers are equal. The core contains the program counter, a 32 x 32-bit register file with two combinational read ports and one clocked write port, an immediate extender, a three-function ALU, the main decoder, a next-PC unit and the datapath multiplexers.

Instruction and data storage are small internal word arrays, each addressed by a word index taken from bits [AW+1:2] of the byte address. The testbench fills both arrays while reset is held. The commit events of each cycle (the register write and the data store) appear on observation ports, together with the PC. These ports are the means by which a surrounding environment follows execution.

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high reset sets the PC to 0 and clears every register, so that an instruction executed right after reset reads zero from any register.
- R2: Opcode 0x00 with funct 0x21 writes R[rs]+R[rt] into R[rd], and with funct 0x23 writes R[rs]-R[rt] into R[rd], both modulo 2^32. Fields: op [31:26], rs [25:21], rt [20:16], rd [15:11], funct [5:0].
- R3: Opcode 0x0D writes R[rs] OR {16'b0, imm[15:0]} into R[rt].
- R4: Opcode 0x23 writes the data word at byte address R[rs] + sign-extended imm into R[rt].
- R5: Opcode 0x2B stores R[rt] at byte address R[rs] + sign-extended imm and writes no register. No other instruction raises the data write enable.
- R6: Opcode 0x04 sets the next PC to PC+4+(sign-extended imm << 2) when R[rs] equals R[rt], and to PC+4 otherwise. It writes neither a register nor memory.
- R7: Any other opcode, and opcode 0x00 with any funct other than 0x21 or 0x23, changes no register and no memory and advances the PC by 4.
- R8: Register 0 always reads as zero. An instruction that targets it raises no register write, and the value stays zero.
- R9: Instruction fetch uses PC bits [IMEM_AW+1:2] and data access uses address bits [DMEM_AW+1:2] as word index, so addresses wrap modulo the array depth. Every instruction other than a taken branch advances the PC by exactly 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pc_o | output | 32 | Address of the instruction executing this cycle |
| rf_we_o | output | 1 | A register write commits at the next edge |
| rf_waddr_o | output | 5 | Register being written |
| rf_wdata_o | output | 32 | Value being written |
| dm_we_o | output | 1 | A data store commits at the next edge |
| dm_addr_o | output | 32 | Byte address computed by the ALU |
| dm_wdata_o | output | 32 | Word being stored |

## Verification
The bench builds the core with 64-word instruction and data arrays (IMEM_AW = DMEM_AW = 6) and with the branch equality taken from the ALU subtraction (EQ_VIA_SUB = 1). The arrays are shallow, so random base registers combined with negative and positive offsets often run past the top of the data array. This exercises the address wrap. The end-of-program branch wraps the PC back into the array as well. Source and destination fields are drawn from a small set of registers. As a result, operands often repeat, both branch outcomes occur, and writes to register 0 show up often. A second reset in the middle of the run, made while the registers hold nonzero values, shows that reset clears them.

// File: rtl/sc_pkg.sv
package sc_pkg;
   localparam int XLEN = 32;

   localparam logic [5:0] OP_RTYPE = 6'h00;
   localparam logic [5:0] OP_ORI   = 6'h0D;
   localparam logic [5:0] OP_LW    = 6'h23;
   localparam logic [5:0] OP_SW    = 6'h2B;
   localparam logic [5:0] OP_BEQ   = 6'h04;
   localparam logic [5:0] FN_ADDU  = 6'h21;
   localparam logic [5:0] FN_SUBU  = 6'h23;

   typedef enum logic [1:0] {
      ALU_ADD = 2'd0,
      ALU_SUB = 2'd1,
      ALU_OR  = 2'd2
   } alu_op_e;

   typedef struct packed {
      logic    dst_is_rd;   // destination field select
      logic    b_from_imm;  // ALU B operand select
      logic    imm_signed;  // extender mode
      logic    wb_from_mem; // write-back source
      logic    reg_wr;
      logic    mem_wr;
      logic    is_branch;
      alu_op_e alu_op;
   } ctrl_t;
endpackage

// File: rtl/sc_decoder.sv
module sc_decoder
   import sc_pkg::*;
(
   input  logic [5:0] op,
   input  logic [5:0] funct,
   output ctrl_t      ctrl
);
   always_comb begin
      ctrl = '{dst_is_rd: 1'b0, b_from_imm: 1'b0, imm_signed: 1'b0,
               wb_from_mem: 1'b0, reg_wr: 1'b0, mem_wr: 1'b0,
               is_branch: 1'b0, alu_op: ALU_ADD};
      unique case (op)
         OP_RTYPE: begin
            if (funct == FN_ADDU || funct == FN_SUBU) begin
               ctrl.dst_is_rd = 1'b1;
               ctrl.reg_wr    = 1'b1;
               ctrl.alu_op    = (funct == FN_SUBU) ? ALU_SUB : ALU_ADD;
            end
         end
         OP_ORI: begin
            ctrl.b_from_imm = 1'b1;
            ctrl.reg_wr     = 1'b1;
            ctrl.alu_op     = ALU_OR;
         end
         OP_LW: begin
            ctrl.b_from_imm  = 1'b1;
            ctrl.imm_signed  = 1'b1;
            ctrl.wb_from_mem = 1'b1;
            ctrl.reg_wr      = 1'b1;
         end
         OP_SW: begin
            ctrl.b_from_imm = 1'b1;
            ctrl.imm_signed = 1'b1;
            ctrl.mem_wr     = 1'b1;
         end
         OP_BEQ: begin
            ctrl.imm_signed = 1'b1;
            ctrl.is_branch  = 1'b1;
            ctrl.alu_op     = ALU_SUB;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
   import sc_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  alu_op_e      op,
   output logic [W-1:0] y,
   output logic         zero
);
   always_comb begin
      unique case (op)
         ALU_SUB: y = a - b;
         ALU_OR:  y = a | b;
         default: y = a + b;
      endcase
   end
   assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
   parameter int W    = 32,
   parameter int NREG = 32,
   localparam int AW  = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          we,
   input  logic [AW-1:0] wa,
   input  logic [W-1:0]  wd,
   input  logic [AW-1:0] ra,
   input  logic [AW-1:0] rb,
   output logic [W-1:0]  rda,
   output logic [W-1:0]  rdb
);
   logic [W-1:0] regs [NREG];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < NREG; i++) regs[i] <= '0;
      end else if (we && wa != '0) begin
         regs[wa] <= wd;
      end
   end

   assign rda = (ra == '0) ? '0 : regs[ra];
   assign rdb = (rb == '0) ? '0 : regs[rb];
endmodule

// File: rtl/sc_wordmem.sv
module sc_wordmem #(
   parameter int W      = 32,
   parameter int AW     = 6,
   localparam int DEPTH = 1 << AW
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [W-1:0]  wdata,
   output logic [W-1:0]  rdata
);
   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[addr] <= wdata;
   end

   assign rdata = mem[addr];
endmodule

// File: rtl/sc_nextpc.sv
module sc_nextpc #(
   parameter int W = 32
) (
   input  logic [W-1:0] pc,
   input  logic [W-1:0] ext_imm,
   input  logic         take,
   output logic [W-1:0] pc_next
);
   logic [W-1:0] seq_pc;
   logic [W-1:0] offset;

   assign seq_pc  = pc + W'(4);
   assign offset  = take ? {ext_imm[W-3:0], 2'b00} : '0;
   assign pc_next = seq_pc + offset;
endmodule

// File: rtl/sc_core.sv
module sc_core
   import sc_pkg::*;
#(
   parameter int IMEM_AW    = 6,
   parameter int DMEM_AW    = 6,
   parameter bit EQ_VIA_SUB = 1'b1
) (
   input  logic        clk,
   input  logic        rst,
   output logic [31:0] pc_o,
   output logic        rf_we_o,
   output logic [4:0]  rf_waddr_o,
   output logic [31:0] rf_wdata_o,
   output logic        dm_we_o,
   output logic [31:0] dm_addr_o,
   output logic [31:0] dm_wdata_o
);
   localparam int NREG = 32;
   localparam int RAW  = $clog2(NREG);

   if (IMEM_AW < 2 || IMEM_AW > 12) begin : g_bad_imem
      $error("sc_core: IMEM_AW out of range 2..12");
   end
   if (DMEM_AW < 2 || DMEM_AW > 12) begin : g_bad_dmem
      $error("sc_core: DMEM_AW out of range 2..12");
   end

   logic [XLEN-1:0] pc, pc_next;
   logic [XLEN-1:0] instr;
   ctrl_t           ctrl;

   logic [5:0]     f_op, f_funct;
   logic [RAW-1:0] f_rs, f_rt, f_rd;
   logic [15:0]    f_imm;

   logic [XLEN-1:0] bus_a, bus_b, ext_imm, alu_b, alu_y, dm_rdata, wb_data;
   logic            alu_zero, equal;
   logic [RAW-1:0]  wb_addr;

   // program counter
   always_ff @(posedge clk) begin
      if (rst) pc <= '0;
      else     pc <= pc_next;
   end

   sc_wordmem #(.W(XLEN), .AW(IMEM_AW)) u_imem (
      .clk(clk), .we(1'b0), .addr(pc[IMEM_AW+1:2]),
      .wdata('0), .rdata(instr)
   );

   assign f_op    = instr[31:26];
   assign f_rs    = instr[25:21];
   assign f_rt    = instr[20:16];
   assign f_rd    = instr[15:11];
   assign f_imm   = instr[15:0];
   assign f_funct = instr[5:0];

   sc_decoder u_dec (.op(f_op), .funct(f_funct), .ctrl(ctrl));

   assign wb_addr = ctrl.dst_is_rd ? f_rd : f_rt;

   sc_regfile #(.W(XLEN), .NREG(NREG)) u_rf (
      .clk(clk), .rst(rst), .we(ctrl.reg_wr), .wa(wb_addr), .wd(wb_data),
      .ra(f_rs), .rb(f_rt), .rda(bus_a), .rdb(bus_b)
   );

   assign ext_imm = ctrl.imm_signed ? {{(XLEN-16){f_imm[15]}}, f_imm}
                                    : {{(XLEN-16){1'b0}}, f_imm};
   assign alu_b   = ctrl.b_from_imm ? ext_imm : bus_b;

   sc_alu #(.W(XLEN)) u_alu (
      .a(bus_a), .b(alu_b), .op(ctrl.alu_op), .y(alu_y), .zero(alu_zero)
   );

   if (EQ_VIA_SUB) begin : g_eq_sub
      assign equal = alu_zero;
   end else begin : g_eq_cmp
      logic unused_zero;
      assign unused_zero = alu_zero;
      assign equal = (bus_a == bus_b);
   end

   sc_wordmem #(.W(XLEN), .AW(DMEM_AW)) u_dmem (
      .clk(clk), .we(ctrl.mem_wr), .addr(alu_y[DMEM_AW+1:2]),
      .wdata(bus_b), .rdata(dm_rdata)
   );

   assign wb_data = ctrl.wb_from_mem ? dm_rdata : alu_y;

   sc_nextpc #(.W(XLEN)) u_npc (
      .pc(pc), .ext_imm(ext_imm), .take(ctrl.is_branch && equal),
      .pc_next(pc_next)
   );

   assign pc_o       = pc;
   assign rf_we_o    = ctrl.reg_wr && (wb_addr != '0);
   assign rf_waddr_o = wb_addr;
   assign rf_wdata_o = wb_data;
   assign dm_we_o    = ctrl.mem_wr;
   assign dm_addr_o  = alu_y;
   assign dm_wdata_o = bus_b;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
   import sc_pkg::*;
(
   input logic        clk,
   input logic        rst,
   input logic [31:0] instr,
   input logic [31:0] pc_o,
   input logic        rf_we_o,
   input logic [4:0]  rf_waddr_o,
   input logic        dm_we_o
);
   logic [5:0] op;
   logic       known_op;
   assign op       = instr[31:26];
   assign known_op = (op == OP_RTYPE) || (op == OP_ORI) || (op == OP_LW) ||
                     (op == OP_SW) || (op == OP_BEQ);

   // R5
   only_store_writes_chk: assert property (@(posedge clk) disable iff (rst)
      dm_we_o |-> op == OP_SW);

   // R6
   branch_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      op == OP_BEQ |-> !rf_we_o && !dm_we_o);

   // R9
   pc_step_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(instr[31:26]) != OP_BEQ) |-> pc_o == $past(pc_o) + 32'd4);

   // R2
   rd_dest_chk: assert property (@(posedge clk) disable iff (rst)
      (rf_we_o && op == OP_RTYPE) |-> rf_waddr_o == instr[15:11]);

   // R3
   rt_dest_chk: assert property (@(posedge clk) disable iff (rst)
      (rf_we_o && op != OP_RTYPE) |-> rf_waddr_o == instr[20:16]);

   // R7
   unknown_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !known_op |-> !rf_we_o && !dm_we_o);
endmodule

bind sc_core sc_core_chk u_chk (
   .clk(clk), .rst(rst), .instr(instr), .pc_o(pc_o),
   .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .dm_we_o(dm_we_o)
);

// File: tb/sc_core_tb.sv
module sc_core_tb;
   localparam int IAW = 6;
   localparam int DAW = 6;
   localparam int ID  = 1 << IAW;
   localparam int DD  = 1 << DAW;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] pc_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
   logic        rf_we_o, dm_we_o;
   logic [4:0]  rf_waddr_o;

   int errors = 0;
   int checks = 0;
   int cycles = 0;

   logic [31:0] prog   [ID];
   logic [31:0] ref_rf [32];
   logic [31:0] ref_dm [DD];
   logic [31:0] ref_pc;

   always #10 clk = ~clk;

   sc_core #(.IMEM_AW(IAW), .DMEM_AW(DAW), .EQ_VIA_SUB(1'b1)) u_dut (
      .clk(clk), .rst(rst), .pc_o(pc_o), .rf_we_o(rf_we_o),
      .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o), .dm_we_o(dm_we_o),
      .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h pc=%h", tag, act, exp, ref_pc);
      end
   endtask

   function automatic logic [31:0] mk_r(int rs, int rt, int rd, logic [5:0] fn);
      return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
   endfunction
   function automatic logic [31:0] mk_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
      return {op, 5'(rs), 5'(rt), imm};
   endfunction

   function automatic logic [31:0] rand_instr();
      int rs = $urandom_range(0, 7);
      int rt = $urandom_range(0, 7);
      int rd = $urandom_range(0, 7);
      logic [15:0] imm = 16'($urandom);
      case ($urandom_range(0, 7))
         0: return mk_r(rs, rt, rd, 6'h21);
         1: return mk_r(rs, rt, rd, 6'h23);
         2: return mk_i(6'h0D, rs, rt, imm);
         3: return mk_i(6'h23, rs, rt, imm);
         4: return mk_i(6'h2B, rs, rt, imm);
         5: return mk_i(6'h04, rs, rt, 16'($urandom_range(0, 3)));
         6: return mk_i(6'h3F, rs, rt, imm);
         default: return mk_r(rs, rt, rd, 6'h20);
      endcase
   endfunction

   task automatic load_program();
      for (int i = 0; i < ID; i++) prog[i] = rand_instr();
      prog[0] = mk_r(1, 2, 3, 6'h21);             // R1: reads after reset are zero
      for (int i = 1; i < 8; i++) prog[i] = mk_i(6'h0D, 0, i, 16'($urandom));
      prog[8]  = mk_i(6'h0D, 1, 0, 16'h1234);     // R8: write to r0
      prog[9]  = mk_r(0, 0, 4, 6'h21);            // R8: r0 reads zero
      prog[10] = mk_r(0, 1, 5, 6'h23);            // R2: negative wrap
      prog[11] = mk_i(6'h2B, 2, 3, 16'hFFF8);     // R5: negative offset
      prog[12] = mk_i(6'h23, 2, 6, 16'hFFF8);     // R4: read it back
      prog[13] = mk_i(6'h04, 6, 3, 16'h0001);     // R6: taken
      prog[15] = mk_i(6'h04, 1, 0, 16'h0002);     // R6: usually not taken
      prog[16] = mk_r(1, 2, 0, 6'h21);            // R8
      prog[17] = 32'hFC00_0000;                   // R7 unknown opcode
      prog[18] = mk_r(1, 2, 3, 6'h00);            // R7 unknown funct
      prog[ID-1] = mk_i(6'h04, 0, 0, 16'(-(ID - 8)));  // R9 wrap to word 8
      for (int i = 0; i < ID; i++) u_dut.u_imem.mem[i] = prog[i];
      for (int i = 0; i < DD; i++) begin
         ref_dm[i] = $urandom;
         u_dut.u_dmem.mem[i] = ref_dm[i];
      end
   endtask

   task automatic model_step();
      logic [31:0] ins = prog[ref_pc[IAW+1:2]];
      logic [5:0]  op = ins[31:26], fn = ins[5:0];
      int          rs = int'(ins[25:21]), rt = int'(ins[20:16]), rd = int'(ins[15:11]);
      logic [31:0] a = ref_rf[rs], b = ref_rf[rt];
      logic [31:0] se = {{16{ins[15]}}, ins[15:0]};
      logic [31:0] ze = {16'd0, ins[15:0]};
      logic [31:0] nxt = ref_pc + 32'd4;
      logic [31:0] wd = '0, ad = '0;
      bit          we = 0, mw = 0;
      int          wa = 0;
      string       tag = "R7";
      if (op == 6'h00 && fn == 6'h21) begin we = 1; wa = rd; wd = a + b; tag = "R2"; end
      else if (op == 6'h00 && fn == 6'h23) begin we = 1; wa = rd; wd = a - b; tag = "R2"; end
      else if (op == 6'h0D) begin we = 1; wa = rt; wd = a | ze; tag = "R3"; end
      else if (op == 6'h23) begin
         ad = a + se; we = 1; wa = rt; wd = ref_dm[ad[DAW+1:2]]; tag = "R4";
      end else if (op == 6'h2B) begin ad = a + se; mw = 1; tag = "R5"; end
      else if (op == 6'h04) begin
         tag = "R6";
         if (a == b) nxt = ref_pc + 32'd4 + {se[29:0], 2'b00};
      end
      if (we && wa == 0) begin we = 0; tag = "R8"; end

      check(pc_o == ref_pc, "R9 pc", pc_o, ref_pc);
      check(rf_we_o == we, {tag, " reg write enable"}, 32'(rf_we_o), 32'(we));
      if (we) begin
         check(rf_waddr_o == 5'(wa), {tag, " dest"}, 32'(rf_waddr_o), 32'(wa));
         check(rf_wdata_o == wd, {tag, " value"}, rf_wdata_o, wd);
      end
      check(dm_we_o == mw, {tag, " store enable"}, 32'(dm_we_o), 32'(mw));
      if (mw) begin
         check(dm_addr_o == ad, "R5 address", dm_addr_o, ad);
         check(dm_wdata_o == b, "R5 data", dm_wdata_o, b);
         ref_dm[ad[DAW+1:2]] = b;
      end
      if (we) ref_rf[wa] = wd;
      ref_pc = nxt;
   endtask

   task automatic do_reset();
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check(pc_o == 32'd0, "R1 reset pc", pc_o, 32'd0);
      rst = 1'b0;
      for (int i = 0; i < 32; i++) ref_rf[i] = '0;
      ref_pc = '0;
   endtask

   task automatic run(int n);
      for (int k = 0; k < n; k++) begin
         model_step();
         @(negedge clk);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=%0d expected<150000", cycles);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int p = 0; p < 3; p++) begin
         rst = 1'b1;
         @(negedge clk);
         load_program();
         do_reset();
         run(400);
      end
      // R1: second reset mid-run with live register contents
      do_reset();
      run(20);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule